// File: doc/BRIEF.md
# Two-Address ALU with Status Flags

This block is the execute-stage arithmetic and logic unit of a small 16-bit two-address RISC datapath. Each operation reads a source operand and the current destination operand and produces the value that goes back into the destination register, so an add computes `Rdest := Rsrc + Rdest`. Register and immediate instruction forms share one datapath: the decoder places either the register value or the extended immediate on the source input, and the ALU cannot tell which form it was given.

Beside the combinational result, the block holds a five-bit status register with the flags F (signed overflow), L (unsigned less-than), C (carry/borrow), N (signed less-than) and Z (equal). Only add, subtract and compare may change these flags. Compare runs the same subtraction as subtract, but it writes a different flag subset and does not write back a result. The flag register changes only on a clock edge with a valid operation.

Top module: `alu16_core`

## Requirements
- R1: Operation codes on `op_i` are ADD=0, SUB=1, CMP=2, AND=3, OR=4, XOR=5, MOV=6, LUI=7, SHL=8, SHR=9. ADD returns `(dst_i + src_i) mod 2^16`, sets C to the carry-out and sets F when the two's-complement sum overflows.
- R2: SUB returns `(dst_i - src_i) mod 2^16`, sets C when the subtraction borrows (`dst_i < src_i` unsigned) and sets F on signed overflow of the difference.
- R3: CMP evaluates `dst_i - src_i` and sets Z when the operands are equal, L when `dst_i < src_i` unsigned and N when `dst_i < src_i` signed.
- R4: CMP leaves C and F unchanged. ADD and SUB leave Z, L and N unchanged.
- R5: AND, OR and XOR return the bitwise combination of `src_i` and `dst_i`. MOV returns `src_i`.
- R6: LUI returns `src_i[7:0]` in bits 15:8 with bits 7:0 cleared.
- R7: SHL returns `dst_i` shifted left by one and SHR returns `dst_i` shifted right by one, each filling the vacated bit with zero.
- R8: AND, OR, XOR, MOV, LUI, SHL, SHR and any undefined code leave every flag unchanged.
- R9: `wr_en_o` is high when `op_valid_i` is high and the code is a defined operation other than CMP. It is low for CMP, for undefined codes and whenever `op_valid_i` is low.
- R10: `flags_o` is `{F,L,C,N,Z}` in bits 4 down to 0. It clears to zero on reset and changes only on a rising clock edge with `op_valid_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag register |
| op_valid_i | input | 1 | Current operation is valid and may update flags |
| op_i | input | 4 | Operation code |
| src_i | input | 16 | Source operand, register value or immediate |
| dst_i | input | 16 | Current destination register value |
| result_o | output | 16 | Value to write back to the destination |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 5 | Status register {F,L,C,N,Z} |

## Verification
Every operation code, including one undefined code, is applied to every pair drawn from sixteen operand values. The values include zero, one, the signed extremes 0x7FFF/0x8000, their neighbours, all-ones and mixed bit patterns. Pairs that straddle the sign boundary show whether F follows signed overflow and N follows signed order rather than unsigned order. Equal pairs and pairs ordered one way unsigned but the other way signed separate Z, L and N. A recurring subset of pairs is sent with `op_valid_i` low, which shows that neither the flags nor the write enable respond to an invalid slot.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_AND = 4'd3,
        OP_OR  = 4'd4,
        OP_XOR = 4'd5,
        OP_MOV = 4'd6,
        OP_LUI = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic f;
        logic l;
        logic c;
        logic n;
        logic z;
    } psr_t;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,      // destination operand
    input  logic [W-1:0] b_i,      // source operand
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         eq_o,
    output logic         ltu_o,
    output logic         lts_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        wide    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o   = wide[W-1:0];
        carry_o = wide[W];
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
        eq_o    = (a_i == b_i);
        ltu_o   = sub_i & ~wide[W];
        lts_o   = sum_o[W-1] ^ ovf_o;
    end
endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W     = 16,
    parameter int IMM_W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] dst_i,
    output logic [W-1:0] res_o,
    output logic         hit_o
);
    localparam int LOW_W = W - IMM_W;

    always_comb begin
        res_o = '0;
        hit_o = 1'b1;
        case (op_i)
            OP_AND:  res_o = src_i & dst_i;
            OP_OR:   res_o = src_i | dst_i;
            OP_XOR:  res_o = src_i ^ dst_i;
            OP_MOV:  res_o = src_i;
            OP_LUI:  res_o = {src_i[IMM_W-1:0], {LOW_W{1'b0}}};
            OP_SHL:  res_o = {dst_i[W-2:0], 1'b0};
            OP_SHR:  res_o = {1'b0, dst_i[W-1:1]};
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid_i,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic [WIDTH-1:0] dst_i,
    output logic [WIDTH-1:0] result_o,
    output logic             wr_en_o,
    output logic [4:0]       flags_o
);
    typedef struct packed {
        psr_t psr;
    } state_t;

    state_t state_d, state_q;

    alu_op_e      op;
    logic         is_sub;
    logic [WIDTH-1:0] sum;
    logic         carry, ovf, eq, ltu, lts;
    logic [WIDTH-1:0] logic_res;
    logic         logic_hit;
    logic [WIDTH-1:0] res_d;
    logic         we_d;

    assign op     = alu_op_e'(op_i);
    assign is_sub = (op == OP_SUB) || (op == OP_CMP);

    alu16_arith #(.W(WIDTH)) arith_i (
        .a_i     (dst_i),
        .b_i     (src_i),
        .sub_i   (is_sub),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (ovf),
        .eq_o    (eq),
        .ltu_o   (ltu),
        .lts_o   (lts)
    );

    alu16_logic #(.W(WIDTH), .IMM_W(IMM_W)) logic_i (
        .op_i  (op),
        .src_i (src_i),
        .dst_i (dst_i),
        .res_o (logic_res),
        .hit_o (logic_hit)
    );

    always_comb begin
        state_d = state_q;
        res_d   = '0;
        we_d    = 1'b0;
        case (op)
            OP_ADD: begin
                res_d           = sum;
                we_d            = 1'b1;
                state_d.psr.c   = carry;
                state_d.psr.f   = ovf;
            end
            OP_SUB: begin
                res_d           = sum;
                we_d            = 1'b1;
                state_d.psr.c   = ~carry;
                state_d.psr.f   = ovf;
            end
            OP_CMP: begin
                res_d           = sum;
                state_d.psr.z   = eq;
                state_d.psr.l   = ltu;
                state_d.psr.n   = lts;
            end
            default: begin
                res_d = logic_res;
                we_d  = logic_hit;
            end
        endcase
        if (!op_valid_i) begin
            state_d = state_q;
            we_d    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_o = res_d;
    assign wr_en_o  = we_d;
    assign flags_o  = state_q.psr;

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> $stable(flags_o));

    // R8
    nonarith_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i > 4'd2) |=> $stable(flags_o));

    // R4
    cmp_keeps_cf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 4'd2) |=> $stable(flags_o[4]) && $stable(flags_o[2]));

    // R4
    addsub_keeps_zln_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i < 4'd2) |=> $stable(flags_o[3]) && $stable(flags_o[1:0]));

    // R3
    cmp_equal_sets_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i == 4'd2 && src_i == dst_i) |=> flags_o[0] && !flags_o[3] && !flags_o[1]);

    // R9
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2 || !op_valid_i) |-> !wr_en_o);
endmodule

// File: tb/alu16_core_tb_top.sv
`timescale 1ns/1ps
module alu16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] src_i = '0;
    logic [15:0] dst_i = '0;
    logic [15:0] result_o;
    logic        wr_en_o;
    logic [4:0]  flags_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;
    logic [4:0] exp_flags = '0;

    always #10 clk = ~clk;

    alu16_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .src_i(src_i), .dst_i(dst_i), .result_o(result_o),
        .wr_en_o(wr_en_o), .flags_o(flags_o)
    );

    function automatic logic [15:0] pick(int k);
        case (k)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
            3: return 16'h007F;  4: return 16'h0080;  5: return 16'h00FF;
            6: return 16'h0100;  7: return 16'h7FFF;  8: return 16'h8000;
            9: return 16'h8001; 10: return 16'hFFFE; 11: return 16'hFFFF;
           12: return 16'h1234; 13: return 16'h5555; 14: return 16'hAAAA;
           default: return 16'hC3A5;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(int o, logic [15:0] s, logic [15:0] d, logic v);
        logic [15:0] er;
        logic        ew;
        logic        defined;
        int          si, di, r;
        string       rq;
        @(negedge clk);
        op_i = o[3:0]; src_i = s; dst_i = d; op_valid_i = v;
        si = $signed(s); di = $signed(d);
        defined = (o <= 9);
        er = '0; rq = "R8";
        case (o)
            0: begin er = d + s; rq = "R1"; end
            1: begin er = d - s; rq = "R2"; end
            2: rq = "R3";
            3: begin er = s & d; rq = "R5"; end
            4: begin er = s | d; rq = "R5"; end
            5: begin er = s ^ d; rq = "R5"; end
            6: begin er = s;     rq = "R5"; end
            7: begin er = {s[7:0], 8'h00}; rq = "R6"; end
            8: begin er = d * 2; rq = "R7"; end
            9: begin er = d / 2; rq = "R7"; end
            default: rq = "R8";
        endcase
        ew = v && defined && (o != 2);
        #1;
        chk("R9", "wr_en", {15'd0, wr_en_o}, {15'd0, ew});
        if (ew) chk(rq, "result", result_o, er);
        if (v) begin
            if (o == 0) begin
                r = di + si;
                exp_flags[2] = ({1'b0, d} + {1'b0, s}) > 17'h0FFFF;
                exp_flags[4] = (r > 32767) || (r < -32768);
            end else if (o == 1) begin
                r = di - si;
                exp_flags[2] = d < s;
                exp_flags[4] = (r > 32767) || (r < -32768);
            end else if (o == 2) begin
                exp_flags[0] = d == s;
                exp_flags[3] = d < s;
                exp_flags[1] = di < si;
            end
        end
        @(negedge clk);
        if (!v) rq = "R10";
        else if (o <= 2) rq = (o == 2) ? "R3 R4" : {rq, " R4"};
        chk(rq, "flags", {11'd0, flags_o}, {11'd0, exp_flags});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                done = 1;
                failures++;
                $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // reset state, with a valid add pending (R10)
        op_valid_i = 1'b1; op_i = 4'd0; src_i = 16'hFFFF; dst_i = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset flags", {11'd0, flags_o}, 16'd0);
        rst_n = 1'b1;
        op_valid_i = 1'b0;
        for (int o = 0; o < 11; o++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    run_op((o == 10) ? 15 : o, pick(i), pick(j), ((i + j + o) % 7) != 3);
                end
            end
        end
        // invalid slot after flags are set must keep them (R10)
        run_op(2, 16'h0000, 16'h8000, 1'b1);
        run_op(2, 16'h0005, 16'h0005, 1'b0);
        run_op(1, 16'h0001, 16'h8000, 1'b0);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule